// File: doc/BRIEF.md
# Multicast Address Hash Filter

This block holds a 256-entry group-address hash table as eight 32-bit registers, and serves two kinds of request on a 48-bit destination address. A command sets or clears the table entry that the address hashes to. A lookup reports whether that entry is set, so that a receive path can decide whether to accept a multicast frame. Both kinds of request hash the address the same way. A CRC-32 runs serially over the six address bytes, one bit per clock. The CRC is then bit-reversed, and its top eight bits form the entry index.

A request is accepted only while the block is idle. `busy` covers the hashing and the single apply cycle. `done` then pulses for one cycle. At that point the table update or the new `hit` value is already visible. All eight registers come out on one flat port, so the surrounding logic can read them at any time.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, `tableRegs` is all zeros and `hit`, `busy` and `done` are 0.
- R2: A request accepted at a clock edge makes `busy` high for exactly 49 cycles, starting at the next edge: 48 CRC cycles and 1 apply cycle. `done` is high for exactly the one cycle in which `busy` first reads low again.
- R3: The index is derived as follows. A CRC register starts at all ones and uses polynomial 0x04C11DB7, shifting toward the MSB. Feedback is the register MSB XOR the input bit. Address byte 0 is `addrIn[47:40]` and byte 5 is `addrIn[7:0]`. The bytes are fed in order from byte 0 to byte 5, and each byte is fed from its LSB first. The 32-bit result is bit-reversed, and its top 8 bits are the index. This means index bit 7 is CRC bit 0 and index bit 0 is CRC bit 7.
- R4: A command with `cmdSet`=1 ORs a one-hot mask into the selected register. Only the selected entry can change.
- R5: A command with `cmdSet`=0 ANDs the selected register with the inverse of the mask. Only the selected entry can change.
- R6: Index bits [7:5] select the register and index bits [4:0] select the entry within it, numbered from the MSB. The mask is 1 shifted left by (31 − bits[4:0]). Register k is `tableRegs[32k+31:32k]`, so entry 0 is `tableRegs[31]` and entry 255 is `tableRegs[224]`.
- R7: A lookup sets `hit` to the value of the selected entry and leaves the table unchanged.
- R8: Requests that arrive while `busy` is high are ignored.
- R9: If `cmdValid` and `lookupValid` are both high while idle, the command is performed and the lookup is dropped.
- R10: `hit` keeps its value until the next lookup completes. Command completions do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrIn | input | 48 | Destination address, byte 0 in bits [47:40] |
| cmdValid | input | 1 | Request to set or clear the entry for `addrIn` |
| cmdSet | input | 1 | 1 = set the entry, 0 = clear it |
| lookupValid | input | 1 | Request to test the entry for `addrIn` |
| tableRegs | output | 256 | The eight hash registers, register k at [32k+31:32k] |
| hit | output | 1 | Result of the latest lookup |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the two extreme entries, 0 and 255. It finds addresses that hash to each of them. A design with the bit numbering reversed, or with the registers swapped, would light `tableRegs[0]` or `tableRegs[255]` instead. Random set, clear and lookup sequences are compared against a bit-level CRC model. A wrong byte order, bit order or reversal would scatter entries and return wrong hits. Requests injected in the middle of a busy period test R8: if they were not ignored, they would modify the table or restart the count. Simultaneous command and lookup requests test R9: the wrong priority would leave the table unchanged and move `hit`.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam logic [31:0] ETH_POLY = 32'h04C1_1DB7;

  typedef struct packed {
    logic load;      // capture address, seed CRC
    logic shift;     // advance CRC by one address bit
    logic write;     // apply set/clear to table
    logic writeSet;  // 1 = OR mask, 0 = AND inverse mask
    logic lookup;    // sample selected entry into hit
  } mhf_strobe_t;
endpackage

// File: rtl/mhf_ctrl.sv
module mhf_ctrl
  import mhf_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdSet,
  input  logic        lookupValid,
  output mhf_strobe_t strb,
  output logic        busy,
  output logic        done
);
  localparam int CNT_W = $clog2(ADDR_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ADDR_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_APPLY} state_t;

  state_t          state;
  logic [CNT_W-1:0] bitCnt;
  logic            opLook;
  logic            opSet;
  logic            accept;

  assign accept = (state == S_IDLE) && (cmdValid || lookupValid);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bitCnt <= '0;
      opLook <= 1'b0;
      opSet  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          state  <= S_RUN;
          bitCnt <= '0;
          opLook <= !cmdValid;  // command wins when both requested
          opSet  <= cmdSet;
        end
        S_RUN: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) state <= S_APPLY;
        end
        S_APPLY: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.load     = accept;
    strb.shift    = (state == S_RUN);
    strb.write    = (state == S_APPLY) && !opLook;
    strb.writeSet = opSet;
    strb.lookup   = (state == S_APPLY) && opLook;
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/mhf_datapath.sv
module mhf_datapath
  import mhf_pkg::*;
#(
  parameter int          ADDR_W   = 48,
  parameter int          CRC_W    = 32,
  parameter int          REG_W    = 32,
  parameter int          NUM_REGS = 8,
  parameter logic [31:0] POLY     = ETH_POLY
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  mhf_strobe_t               strb,
  input  logic [ADDR_W-1:0]         addrIn,
  output logic [REG_W*NUM_REGS-1:0] tableRegs,
  output logic                      hit
);
  localparam int TBL_W = REG_W * NUM_REGS;
  localparam int IDX_W = $clog2(TBL_W);
  localparam int BIT_W = $clog2(REG_W);
  localparam int NUM_BYTES = ADDR_W / 8;

  logic [ADDR_W-1:0] ordered;
  logic [ADDR_W-1:0] bitQueue;
  logic [CRC_W-1:0]  crc;
  logic [CRC_W-1:0]  crcNext;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  flatPos;
  logic [TBL_W-1:0]  mask;
  logic              feedback;

  // Bit i of the queue is the i-th bit on the wire: byte 0 first, LSB first.
  genvar gb, gk;
  generate
    for (gb = 0; gb < NUM_BYTES; gb++) begin : g_byte
      for (gk = 0; gk < 8; gk++) begin : g_bit
        assign ordered[8*gb + gk] = addrIn[ADDR_W - 8*(gb+1) + gk];
      end
    end
  endgenerate

  assign feedback = crc[CRC_W-1] ^ bitQueue[0];
  assign crcNext  = {crc[CRC_W-2:0], 1'b0} ^ (feedback ? POLY[CRC_W-1:0] : '0);

  // Top bits of the reversed CRC are the low CRC bits, reversed.
  genvar gi;
  generate
    for (gi = 0; gi < IDX_W; gi++) begin : g_idx
      assign idx[IDX_W-1-gi] = crc[gi];
    end
  endgenerate

  // Register select stays, in-register bit counts from the MSB.
  assign flatPos = {idx[IDX_W-1:BIT_W], ~idx[BIT_W-1:0]};
  assign mask    = {{(TBL_W-1){1'b0}}, 1'b1} << flatPos;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitQueue  <= '0;
      crc       <= '1;
      tableRegs <= '0;
      hit       <= 1'b0;
    end else begin
      if (strb.load) begin
        bitQueue <= ordered;
        crc      <= '1;
      end else if (strb.shift) begin
        bitQueue <= bitQueue >> 1;
        crc      <= crcNext;
      end
      if (strb.write)
        tableRegs <= strb.writeSet ? (tableRegs | mask) : (tableRegs & ~mask);
      if (strb.lookup)
        hit <= tableRegs[flatPos];
    end
  end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int CRC_W    = 32,
  parameter int REG_W    = 32,
  parameter int NUM_REGS = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         addrIn,
  input  logic                      cmdValid,
  input  logic                      cmdSet,
  input  logic                      lookupValid,
  output logic [REG_W*NUM_REGS-1:0] tableRegs,
  output logic                      hit,
  output logic                      busy,
  output logic                      done
);
  mhf_strobe_t strb;

  mhf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdSet(cmdSet),
    .lookupValid(lookupValid), .strb(strb), .busy(busy), .done(done)
  );

  mhf_datapath #(
    .ADDR_W(ADDR_W), .CRC_W(CRC_W), .REG_W(REG_W), .NUM_REGS(NUM_REGS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addrIn(addrIn),
    .tableRegs(tableRegs), .hit(hit)
  );
endmodule

// File: rtl/mcast_hash_filter_chk.sv
module mcast_hash_filter_chk #(
  parameter int TBL_W = 256
) (
  input logic             clk,
  input logic             rstN,
  input logic [TBL_W-1:0] tableRegs,
  input logic             hit,
  input logic             busy,
  input logic             done
);
  // R2
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R2
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R4
  single_entry_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($countones(tableRegs ^ $past(tableRegs)) <= 1));

  // R7
  table_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(tableRegs));

  // R10
  hit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(hit));
endmodule

bind mcast_hash_filter mcast_hash_filter_chk #(.TBL_W(REG_W*NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .tableRegs(tableRegs), .hit(hit),
  .busy(busy), .done(done)
);

// File: tb/test_mcast_hash_filter.sv
`timescale 1ns/1ps
module test_mcast_hash_filter;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [47:0]  addrIn = '0;
  logic         cmdValid = 1'b0, cmdSet = 1'b0, lookupValid = 1'b0;
  logic [255:0] tableRegs;
  logic         hit, busy, done;

  int tests = 0, fails = 0;
  logic [255:0] model = '0;
  logic         lastHit = 1'b0;

  always #2 clk = ~clk;

  mcast_hash_filter i_mcast_hash_filter (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .cmdValid(cmdValid),
    .cmdSet(cmdSet), .lookupValid(lookupValid), .tableRegs(tableRegs),
    .hit(hit), .busy(busy), .done(done)
  );

  // R3: reference index from the spec
  function automatic logic [7:0] refIndex(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [7:0]  r;
    for (int j = 0; j < 6; j++) begin
      logic [7:0] b = a[47-8*j -: 8];
      for (int k = 0; k < 8; k++) begin
        logic fb = c[31] ^ b[k];
        c = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
      end
    end
    for (int i = 0; i < 8; i++) r[7-i] = c[i];
    return r;
  endfunction

  // R6: entry number to flat bit position
  function automatic int flatOf(input logic [7:0] e);
    return 32 * (int'(e) / 32) + 31 - (int'(e) % 32);
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one request; optionally inject a request mid-flight (R8).
  task automatic doOp(input logic [47:0] a, input logic c, input logic s,
                      input logic l, input logic inject, output int busyLen);
    @(negedge clk);
    addrIn = a; cmdValid = c; cmdSet = s; lookupValid = l;
    @(negedge clk);
    cmdValid = 0; lookupValid = 0;
    busyLen = 0;
    while (busy && busyLen < 200) begin
      busyLen++;
      if (inject && busyLen == 10) begin
        addrIn = ~a; cmdValid = 1; cmdSet = 1; lookupValid = 1;
      end else begin
        cmdValid = 0; lookupValid = 0;
      end
      @(negedge clk);
    end
    cmdValid = 0; lookupValid = 0;
    check("R2 done pulse", {255'b0, done}, 256'd1);
    if (c) begin
      if (s) model[flatOf(refIndex(a))] = 1'b1;
      else   model[flatOf(refIndex(a))] = 1'b0;
    end else if (l) begin
      lastHit = model[flatOf(refIndex(a))];
    end
    check(c ? (s ? "R4 set table" : "R5 clear table") : "R7 table unchanged",
          tableRegs, model);
    check(l && !c ? "R7 hit value" : "R10 hit held", {255'b0, hit}, {255'b0, lastHit});
  endtask

  initial begin
    #(4 * 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    logic [47:0] a0, a255, a;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset table", tableRegs, '0);
    check("R1 reset flags", {253'b0, hit, busy, done}, '0);
    rstN = 1;
    @(negedge clk);

    // find corner addresses for entries 0 and 255
    a0 = '0; a255 = '0;
    for (int t = 0; t < 20000; t++) begin
      a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      if (refIndex(a) == 8'd0   && a0 == '0)   a0 = a;
      if (refIndex(a) == 8'd255 && a255 == '0) a255 = a;
    end

    // R2 busy length, R6 entry 0 at MSB of register 0
    doOp(a0, 1, 1, 0, 0, n);
    check("R2 busy length", 256'(n), 256'd49);
    check("R6 entry0 position", {255'b0, tableRegs[31]}, 256'd1);
    doOp(a255, 1, 1, 0, 0, n);
    check("R6 entry255 position", {255'b0, tableRegs[224]}, 256'd1);
    doOp(a255, 0, 1, 1, 0, n);  // R7 lookup hit
    doOp(a255, 1, 0, 0, 0, n);  // R5 clear
    doOp(a255, 0, 0, 1, 0, n);  // R7 miss

    // R9 both requests: command wins
    doOp(a255, 1, 1, 1, 0, n);
    check("R9 command priority", {255'b0, tableRegs[224]}, 256'd1);

    // R8 requests during busy ignored
    doOp(a0, 0, 0, 1, 1, n);
    check("R8 busy length unchanged", 256'(n), 256'd49);
    repeat (2) @(negedge clk);
    check("R8 no restart", {255'b0, busy}, '0);
    check("R8 table untouched", tableRegs, model);

    // random mix
    for (int t = 0; t < 120; t++) begin
      int op = $urandom_range(0, 2);
      a = (t % 3 == 0) ? {$urandom, $urandom} : ((t % 2) ? a0 : {$urandom, $urandom});
      doOp(a, op != 2, op == 0, op == 2, 0, n);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule